// File: doc/BRIEF.md
# Display Link Control Register Bank

This block is the configuration and status register file that sits beside a display serializer. A serial-to-parallel bus adapter upstream presents byte-wide register accesses: an address, a write strobe with data, and a read strobe. Read data comes back one cycle after the read strobe. The bank returns fixed identification and frequency-limit bytes. It holds the control bits that steer the serializer: output-driver enable, capture edge, bus width, clock type and the two sync-enable bits. The HSYNC and VSYNC pass through the bank and are gated by those enable bits.

It also watches two external detect lines, a receiver-sense line and a hot-plug line. Both are synchronized with two flops. A level change on the line that software has selected drops an active-low sticky monitor flag. Software restores the flag by writing a one to it. A three-bit selector chooses what drives a single status pin: a constant high, the monitor flag, or either detect line.

Register map: 00h vendor ID low (05h), 01h vendor ID high (13h), 02h device ID low (24h), 03h device ID high (67h), 04h revision (00h), 06h low frequency limit (19h), 07h high frequency limit (55h). 08h is control register A and 09h is control/status register B. All other addresses read 00h.

Top module: `dlink_regbank`

## Requirements
- R1: Reads of 00h, 01h, 02h, 03h and 04h return 05h, 13h, 24h, 67h and 00h.
- R2: Reads of 06h and 07h return 19h and 55h.
- R3: Control register A at 08h holds six read/write bits. Bit0 is the driver enable, bit1 the edge select, bit2 the dual-bus select, bit3 the single-ended clock select, bit4 the horizontal sync enable and bit5 the vertical sync enable. Bits 7:6 read 0. The reset value is 3Bh.
- R4: `drv_en_o` follows bit0 of control register A. `edge_sel_o`, `dual_bus_o` and `se_clk_o` follow bits 1, 2 and 3.
- R5: `hsync_o` equals `hsync_i` while the horizontal sync enable is 1 and is 0 otherwise. `vsync_o` follows `vsync_i` under the vertical sync enable in the same way.
- R6: Register B at 09h has this layout. Bit0 is the monitor flag. Bit1 is the synchronized hot-plug line and bit2 the synchronized receiver-sense line. Bit3 is the source select. Bits 6:4 are the pin select. Bit7 is the synchronized low-swing line. The flag resets to 1, the source select to 0 and the pin select to 001.
- R7: The monitor flag goes to 0 one cycle after a level change leaves the two-flop synchronizer of the selected line. Source select 0 watches receiver sense and 1 watches hot-plug. A level change on the other line leaves the flag unchanged.
- R8: Writing 09h with bit0 = 1 sets the flag to 1. If a level change on the selected line is detected in the same cycle, the flag stays 0.
- R9: The status pin is driven as follows for each pin-select code: 000 drives 1, 001 drives the monitor flag, 010 drives synchronized receiver sense, 011 drives synchronized hot-plug, and 1xx drives 1.
- R10: Writes to read-only bytes, to read-only bits of 09h, and to unmapped addresses change nothing. Unmapped addresses read 00h.
- R11: `reg_rdata` is loaded on the clock edge where `reg_rd` is 1 and holds its value while `reg_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| rx_sense_i | input | 1 | Asynchronous receiver-sense line |
| hot_plug_i | input | 1 | Asynchronous hot-plug line |
| low_swing_i | input | 1 | Asynchronous low-swing indication |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| hsync_o | output | 1 | Gated horizontal sync |
| vsync_o | output | 1 | Gated vertical sync |
| drv_en_o | output | 1 | Output-driver enable (0 = drivers tri-stated) |
| edge_sel_o | output | 1 | Capture edge select (1 = falling first) |
| dual_bus_o | output | 1 | Dual 12-bit bus select |
| se_clk_o | output | 1 | Single-ended clock select |
| status_pin_o | output | 1 | Selected status output |

## Verification
A level change on the watched detect line and a software write-one clear of the monitor flag can land on the same clock edge. The bench first clears the flag. It then toggles the hot-plug line away from the clock edge and counts two synchronizer edges. It places the write to 09h so that it is sampled on the exact edge where the change is detected. The flag must then read 0, and a later clear with no event must bring it back to 1.

// File: rtl/dlink_regbank.sv
module dlink_regbank #(
  parameter logic [15:0] VENDOR_ID = 16'h1305,
  parameter logic [15:0] DEVICE_ID = 16'h6724,
  parameter logic [7:0]  REVISION  = 8'h00,
  parameter logic [7:0]  FREQ_LO   = 8'h19,
  parameter logic [7:0]  FREQ_HI   = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  input  logic       rx_sense_i,
  input  logic       hot_plug_i,
  input  logic       low_swing_i,
  input  logic       hsync_i,
  input  logic       vsync_i,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       drv_en_o,
  output logic       edge_sel_o,
  output logic       dual_bus_o,
  output logic       se_clk_o,
  output logic       status_pin_o
);

  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h09;

  logic       drv_en, edge_sel, dual_bus, se_clk, hsync_en, vsync_en;
  logic       mdi_n, src_sel;
  logic [2:0] pin_sel;
  logic [2:0] sync1, sync2;
  logic       rs_q, hp_q;
  logic       rs_s, hp_s, ls_s;
  logic       det_change;
  logic       wr_ctrl, wr_stat;
  logic [7:0] rd_mux;
  logic       unused_wbits;

  assign unused_wbits = ^{reg_wdata[7:6], reg_wdata[2:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      rs_q  <= 1'b0;
      hp_q  <= 1'b0;
    end else begin
      sync1 <= {low_swing_i, hot_plug_i, rx_sense_i};
      sync2 <= sync1;
      rs_q  <= sync2[0];
      hp_q  <= sync2[1];
    end
  end

  assign rs_s = sync2[0];
  assign hp_s = sync2[1];
  assign ls_s = sync2[2];

  assign det_change = src_sel ? (hp_s ^ hp_q) : (rs_s ^ rs_q);

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_en   <= 1'b1;
      edge_sel <= 1'b1;
      dual_bus <= 1'b0;
      se_clk   <= 1'b1;
      hsync_en <= 1'b1;
      vsync_en <= 1'b1;
    end else if (wr_ctrl) begin
      drv_en   <= reg_wdata[0];
      edge_sel <= reg_wdata[1];
      dual_bus <= reg_wdata[2];
      se_clk   <= reg_wdata[3];
      hsync_en <= reg_wdata[4];
      vsync_en <= reg_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel <= 1'b0;
      pin_sel <= 3'b001;
    end else if (wr_stat) begin
      src_sel <= reg_wdata[3];
      pin_sel <= reg_wdata[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mdi_n <= 1'b1;
    else if (det_change)
      mdi_n <= 1'b0;
    else if (wr_stat && reg_wdata[0])
      mdi_n <= 1'b1;
  end

  always_comb begin
    case (reg_addr)
      8'h00:   rd_mux = VENDOR_ID[7:0];
      8'h01:   rd_mux = VENDOR_ID[15:8];
      8'h02:   rd_mux = DEVICE_ID[7:0];
      8'h03:   rd_mux = DEVICE_ID[15:8];
      8'h04:   rd_mux = REVISION;
      8'h06:   rd_mux = FREQ_LO;
      8'h07:   rd_mux = FREQ_HI;
      A_CTRL:  rd_mux = {2'b00, vsync_en, hsync_en, se_clk, dual_bus, edge_sel, drv_en};
      A_STAT:  rd_mux = {ls_s, pin_sel, src_sel, rs_s, hp_s, mdi_n};
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rdata <= 8'h00;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  always_comb begin
    case (pin_sel)
      3'b001:  status_pin_o = mdi_n;
      3'b010:  status_pin_o = rs_s;
      3'b011:  status_pin_o = hp_s;
      default: status_pin_o = 1'b1;
    endcase
  end

  assign hsync_o    = hsync_i & hsync_en;
  assign vsync_o    = vsync_i & vsync_en;
  assign drv_en_o   = drv_en;
  assign edge_sel_o = edge_sel;
  assign dual_bus_o = dual_bus;
  assign se_clk_o   = se_clk;

endmodule

module dlink_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       reg_rd,
  input logic [7:0] reg_rdata,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic       status_pin_o,
  input logic       hen,
  input logic       ven,
  input logic       mdi,
  input logic       chg,
  input logic [2:0] msel,
  input logic [5:0] ctrl_a
);

  // R5
  hsync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !hen |-> !hsync_o);

  // R5
  vsync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !ven |-> !vsync_o);

  // R8
  mdi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h09 && reg_wdata[0] && !chg) |=> mdi);

  // R8
  mdi_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) chg |=> !mdi);

  // R7
  mdi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdi && !(reg_wr && reg_addr == 8'h09 && reg_wdata[0])) |=> !mdi);

  // R9
  pin_forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msel == 3'b000 || msel[2]) |-> status_pin_o);

  // R10
  ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 8'h08) |=> $stable(ctrl_a));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind dlink_regbank dlink_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .status_pin_o(status_pin_o),
  .hen(hsync_en), .ven(vsync_en), .mdi(mdi_n), .chg(det_change),
  .msel(pin_sel), .ctrl_a({vsync_en, hsync_en, se_clk, dual_bus, edge_sel, drv_en})
);

// File: tb/dlink_regbank_tb.sv
`timescale 1ns/1ps
module dlink_regbank_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       rx_sense_i = 1'b0, hot_plug_i = 1'b0, low_swing_i = 1'b1;
  logic       hsync_i = 1'b0, vsync_i = 1'b0;
  logic       hsync_o, vsync_o, drv_en_o, edge_sel_o, dual_bus_o, se_clk_o, status_pin_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dlink_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .rx_sense_i(rx_sense_i), .hot_plug_i(hot_plug_i), .low_swing_i(low_swing_i),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .drv_en_o(drv_en_o), .edge_sel_o(edge_sel_o), .dual_bus_o(dual_bus_o),
    .se_clk_o(se_clk_o), .status_pin_o(status_pin_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset rdata", reg_rdata, 8'h00);
    check("R4 reset outputs", {4'h0, drv_en_o, edge_sel_o, dual_bus_o, se_clk_o}, 8'h0D);
    check("R9 reset pin=flag", {7'h0, status_pin_o}, 8'h01);
    rd_chk("R1 vid lo", 8'h00, 8'h05);
    rd_chk("R1 vid hi", 8'h01, 8'h13);
    rd_chk("R1 did lo", 8'h02, 8'h24);
    rd_chk("R1 did hi", 8'h03, 8'h67);
    rd_chk("R1 rev", 8'h04, 8'h00);
    rd_chk("R2 freq lo", 8'h06, 8'h19);
    rd_chk("R2 freq hi", 8'h07, 8'h55);
    rd_chk("R3 ctrl A reset", 8'h08, 8'h3B);
    rd_chk("R6 reg B reset", 8'h09, 8'h91);
  endtask

  task automatic t_ctrl();
    @(negedge clk); hsync_i = 1'b1; vsync_i = 1'b1;
    @(negedge clk);
    check("R5 sync pass", {6'h0, hsync_o, vsync_o}, 8'h03);
    wr(8'h08, 8'h00);
    rd_chk("R3 ctrl A zero", 8'h08, 8'h00);
    check("R5 sync gated", {6'h0, hsync_o, vsync_o}, 8'h00);
    check("R4 outputs zero", {4'h0, drv_en_o, edge_sel_o, dual_bus_o, se_clk_o}, 8'h00);
    wr(8'h08, 8'h10);
    check("R5 h only", {6'h0, hsync_o, vsync_o}, 8'h02);
    wr(8'h08, 8'hFF);
    rd_chk("R3 ctrl A ones", 8'h08, 8'h3F);
    check("R4 outputs ones", {4'h0, drv_en_o, edge_sel_o, dual_bus_o, se_clk_o}, 8'h0F);
    @(negedge clk); hsync_i = 1'b0;
    @(negedge clk);
    check("R5 h follows low", {6'h0, hsync_o, vsync_o}, 8'h01);
    wr(8'h08, 8'h3B);
  endtask

  task automatic t_ro();
    wr(8'h00, 8'hAA);
    rd_chk("R10 ro id", 8'h00, 8'h05);
    wr(8'h07, 8'h00);
    rd_chk("R10 ro freq", 8'h07, 8'h55);
    wr(8'h05, 8'h5A);
    rd_chk("R10 unmapped", 8'h05, 8'h00);
    rd_chk("R10 ctrl A kept", 8'h08, 8'h3B);
    wr(8'h09, 8'h86);
    rd_chk("R10 ro bits B", 8'h09, 8'h81);
    wr(8'h09, 8'h10);
    rd_chk("R6 B restored", 8'h09, 8'h91);
    @(negedge clk); reg_addr = 8'h01;
    @(negedge clk);
    check("R11 hold", reg_rdata, 8'h91);
  endtask

  task automatic t_mdi();
    @(negedge clk); rx_sense_i = 1'b1;
    settle();
    rd_chk("R7 rsen event", 8'h09, 8'h94);
    check("R9 pin flag low", {7'h0, status_pin_o}, 8'h00);
    settle();
    rd_chk("R7 sticky", 8'h09, 8'h94);
    wr(8'h09, 8'h11);
    rd_chk("R8 cleared", 8'h09, 8'h95);
    check("R9 pin flag high", {7'h0, status_pin_o}, 8'h01);
  endtask

  task automatic t_src();
    wr(8'h09, 8'h19);
    @(negedge clk); rx_sense_i = 1'b0;
    settle();
    rd_chk("R7 other line ignored", 8'h09, 8'h99);
    @(negedge clk); hot_plug_i = 1'b1;
    settle();
    rd_chk("R7 hot-plug event", 8'h09, 8'h9A);
  endtask

  task automatic t_collide();
    wr(8'h09, 8'h19);
    rd_chk("R8 pre-clear", 8'h09, 8'h9B);
    @(negedge clk); hot_plug_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 8'h09; reg_wdata = 8'h19; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R8 event beats clear", 8'h09, 8'h98);
    wr(8'h09, 8'h19);
    rd_chk("R8 later clear", 8'h09, 8'h99);
  endtask

  task automatic t_pin();
    @(negedge clk); hot_plug_i = 1'b1;
    settle();
    wr(8'h09, 8'h08);
    check("R9 code 000", {7'h0, status_pin_o}, 8'h01);
    wr(8'h09, 8'h18);
    check("R9 code 001", {7'h0, status_pin_o}, 8'h00);
    wr(8'h09, 8'h28);
    check("R9 code 010 low", {7'h0, status_pin_o}, 8'h00);
    @(negedge clk); rx_sense_i = 1'b1;
    settle();
    check("R9 code 010 high", {7'h0, status_pin_o}, 8'h01);
    wr(8'h09, 8'h38);
    check("R9 code 011 high", {7'h0, status_pin_o}, 8'h01);
    @(negedge clk); hot_plug_i = 1'b0;
    settle();
    check("R9 code 011 low", {7'h0, status_pin_o}, 8'h00);
    wr(8'h09, 8'h48);
    check("R9 code 100", {7'h0, status_pin_o}, 8'h01);
    wr(8'h09, 8'h78);
    check("R9 code 111", {7'h0, status_pin_o}, 8'h01);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_ctrl();
    t_ro();
    t_mdi();
    t_src();
    t_collide();
    t_pin();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule